// File: doc/BRIEF.md
# Posit Adder (16-bit, one exponent bit)

This block adds two posit operands and returns their posit sum. Each operand is unpacked into a sign, a scale and a significand. For a negative operand the two's complement is taken first. The length of the regime run is then counted to find the regime value. The scale is four to the power of the regime times two to the power of the exponent field. The significand is one plus the fraction.

The operand of smaller magnitude is shifted right to the scale of the larger one. Bits shifted out are collapsed into a sticky bit. The significands are added when the signs agree and subtracted when they differ. The raw sum is normalised with a leading-zero count and packed back into a regime, an exponent and a fraction. It is then rounded in the bit-pattern domain.

NaR, zero operands and exact cancellation bypass the arithmetic path. An optional output register sets the latency to one cycle or zero. Width and exponent size are parameters, with defaults of 16 and 1.

Top module: `posit_adder`

## Requirements
- R1: Operands and result are N-bit posits with ES exponent bits (defaults 16 and 1). The MSB is the sign and a negative posit is the two's complement of its magnitude pattern. 0...0 is zero and 1 followed by zeros is NaR. A magnitude pattern 0|regime|exponent|fraction has value 4^k * 2^e * (1+f). Here k is run-1 for a run of ones and -run for a run of zeros. Exponent bits cut off by the pattern's end count as 0.
- R2: If either operand is NaR, the result is NaR.
- R3: If one operand is zero and the other is not NaR, the result is the other operand unchanged.
- R4: An operand added to its own negation (two's complement pattern) gives 0...0.
- R5: Every other result is the exact sum rounded to nearest in the pattern domain. The decision point between adjacent patterns p and p+1 is the value of the (N+1)-bit posit formed by p followed by a 1. A tie goes to the pattern whose LSB is 0.
- R6: A sum whose magnitude is at or above maxpos (0111...1) gives ±maxpos. A result is never NaR unless an operand is NaR.
- R7: A nonzero exact sum never gives zero. Magnitudes at or below minpos (0...01) give ±minpos.
- R8: The result does not depend on operand order.
- R9: Negating both operands negates the result.
- R10: With OUT_REG = 1, the result appears on sum_o one clock edge after the operands are presented. sum_o is 0 while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | N | First posit operand |
| b_i | input | N | Second posit operand |
| sum_o | output | N | Posit sum |

## Verification
The alignment sticky bit and the round-to-nearest-even tie decision both act in the same cycle. A sticky bit from far-shifted bits must turn an apparent tie into a round-up or a round-down. Rounding can also carry a pattern into the maxpos saturation boundary in the same evaluation.

Both interactions are provoked by sweeping every operand pair of an 8-bit, one-exponent-bit instance. Many of those pairs have large scale gaps and opposite signs. Each result is judged against a bench model that sums decoded values exactly and picks the nearest pattern using the (N+1)-bit midpoint rule. Directed pairs on a 16-bit instance cover the default width.

// File: rtl/posit_pkg.sv
package posit_pkg;

  typedef enum logic [2:0] {
    RES_SUM,
    RES_NAR,
    RES_A,
    RES_B,
    RES_ZERO
  } res_sel_e;

  function automatic int scale_width(int n, int es);
    return $clog2(n << es) + 2;
  endfunction

endpackage

// File: rtl/posit_lzc.sv
module posit_lzc #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  v_i,
  output logic [CW-1:0] cnt_o
);

  // highest set bit wins: later iterations overwrite
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (v_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/posit_unpack.sv
module posit_unpack #(
  parameter int N   = 16,
  parameter int ES  = 1,
  parameter int SCW = 7,
  parameter int FW  = N - ES - 3
) (
  input  logic [N-1:0]          p_i,
  output logic                  nar_o,
  output logic                  zero_o,
  output logic                  sign_o,
  output logic signed [SCW-1:0] scale_o,
  output logic [FW:0]           sig_o
);

  localparam int BW = N - 1;
  localparam int RW = $clog2(BW + 1);

  logic [BW-1:0]         body, runv, rest;
  logic                  r0;
  logic [RW-1:0]         run;
  logic signed [SCW-1:0] run_s, k;
  logic [ES-1:0]         expo;
  logic [FW-1:0]         frac;

  assign nar_o  = (p_i == {1'b1, {(N-1){1'b0}}});
  assign zero_o = (p_i == '0);
  assign sign_o = p_i[N-1];

  assign body = BW'(sign_o ? (~p_i + 1'b1) : p_i);
  assign r0   = body[BW-1];
  assign runv = r0 ? ~body : body;

  posit_lzc #(.W(BW), .CW(RW)) u_run_lzc (
    .v_i  (runv),
    .cnt_o(run)
  );

  // drop regime run and its terminator
  assign rest = body << ({1'b0, run} + (RW+1)'(1));
  assign {expo, frac} = (ES+FW)'(rest >> 2);

  assign run_s   = $signed({{(SCW-RW){1'b0}}, run});
  assign k       = r0 ? (run_s - SCW'(1)) : -run_s;
  assign scale_o = (k <<< ES) + $signed({{(SCW-ES){1'b0}}, expo});
  assign sig_o   = {1'b1, frac};

endmodule

// File: rtl/posit_align_add.sv
module posit_align_add #(
  parameter int SW  = 13,
  parameter int SCW = 7,
  parameter int AW  = SW + 3
) (
  input  logic                  a_sign_i,
  input  logic signed [SCW-1:0] a_scale_i,
  input  logic [SW-1:0]         a_sig_i,
  input  logic                  b_sign_i,
  input  logic signed [SCW-1:0] b_scale_i,
  input  logic [SW-1:0]         b_sig_i,
  output logic                  sign_o,
  output logic signed [SCW-1:0] scale_o,
  output logic [AW:0]           sum_o
);

  logic                  swap, s_sign;
  logic signed [SCW-1:0] s_scale;
  logic [SW-1:0]         l_sig, s_sig;
  logic signed [SCW:0]   d;
  logic [SCW:0]          diff;
  logic [AW-1:0]         l_ext, s_ext, s_sh, s_al;
  logic                  lost;

  assign swap = (b_scale_i > a_scale_i) ||
                ((b_scale_i == a_scale_i) && (b_sig_i > a_sig_i));

  assign sign_o  = swap ? b_sign_i  : a_sign_i;
  assign scale_o = swap ? b_scale_i : a_scale_i;
  assign l_sig   = swap ? b_sig_i   : a_sig_i;
  assign s_sign  = swap ? a_sign_i  : b_sign_i;
  assign s_scale = swap ? a_scale_i : b_scale_i;
  assign s_sig   = swap ? a_sig_i   : b_sig_i;

  assign d    = {scale_o[SCW-1], scale_o} - {s_scale[SCW-1], s_scale};
  assign diff = d;

  // guard, round and sticky slots below the significand
  assign l_ext = {l_sig, 3'b000};
  assign s_ext = {s_sig, 3'b000};
  assign s_sh  = s_ext >> diff;
  assign lost  = ((s_sh << diff) != s_ext);
  assign s_al  = {s_sh[AW-1:1], s_sh[0] | lost};

  assign sum_o = (sign_o ^ s_sign) ? ({1'b0, l_ext} - {1'b0, s_al})
                                   : ({1'b0, l_ext} + {1'b0, s_al});

endmodule

// File: rtl/posit_pack.sv
module posit_pack #(
  parameter int N   = 16,
  parameter int ES  = 1,
  parameter int SCW = 7,
  parameter int AW  = 16
) (
  input  logic                  sign_i,
  input  logic signed [SCW-1:0] scale_i,
  input  logic [AW:0]           sum_i,
  output logic [N-1:0]          p_o
);

  localparam int LCW = $clog2(AW + 2);
  localparam int ESW = SCW + 2;
  localparam int SHW = $clog2(N);
  localparam int YW  = 2 + ES + AW + N;
  localparam logic signed [ESW-1:0] MAX_SC = ESW'((N - 2) << ES);
  localparam logic signed [ESW-1:0] MIN_SC = -MAX_SC;

  logic [LCW-1:0]        lz;
  logic [AW-1:0]         frac;
  logic signed [ESW-1:0] sc, k;
  logic                  rb, sat_hi, sat_lo, guard, sticky, inc;
  logic [ES-1:0]         expo;
  logic [SHW-1:0]        sh;
  logic [YW-1:0]         x0, y;
  logic [N-2:0]          body, body_r;
  logic [N-1:0]          mag;

  posit_lzc #(.W(AW+1), .CW(LCW)) u_norm_lzc (
    .v_i  (sum_i),
    .cnt_o(lz)
  );

  assign frac = AW'(sum_i << lz);
  assign sc   = $signed({{2{scale_i[SCW-1]}}, scale_i}) + ESW'(1)
              - $signed({{(ESW-LCW){1'b0}}, lz});

  assign sat_hi = (sc > MAX_SC);
  assign sat_lo = (sc < MIN_SC);

  assign k    = sc >>> ES;
  assign expo = sc[ES-1:0];
  assign rb   = ~k[ESW-1];
  assign sh   = SHW'(rb ? k : ~k);

  // regime built by sign-filling shift of {rb, ~rb, exp, frac}
  assign x0 = {rb, ~rb, expo, frac, {N{1'b0}}};
  assign y  = rb ? ~((~x0) >> sh) : (x0 >> sh);

  assign body   = y[YW-1 -: N-1];
  assign guard  = y[YW-N];
  assign sticky = |y[YW-N-1:0];
  assign inc    = guard & (sticky | body[0]);
  assign body_r = body + (N-1)'(inc);

  always_comb begin
    if (sat_hi)      mag = {1'b0, {(N-1){1'b1}}};
    else if (sat_lo) mag = N'(1);
    else             mag = {1'b0, body_r};
  end

  assign p_o = sign_i ? (~mag + 1'b1) : mag;

endmodule

// File: rtl/posit_adder.sv
module posit_adder
  import posit_pkg::*;
#(
  parameter int N       = 16,
  parameter int ES      = 1,
  parameter int OUT_REG = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] sum_o
);

  localparam int FW  = N - ES - 3;
  localparam int SW  = FW + 1;
  localparam int AW  = SW + 3;
  localparam int SCW = scale_width(N, ES);
  localparam logic [N-1:0] NAR = {1'b1, {(N-1){1'b0}}};

  logic                  a_nar, a_zero, a_sign, b_nar, b_zero, b_sign;
  logic signed [SCW-1:0] a_scale, b_scale, r_scale;
  logic [SW-1:0]         a_sig, b_sig;
  logic                  r_sign;
  logic [AW:0]           r_sum;
  logic [N-1:0]          packed_sum, res;
  res_sel_e              sel;

  posit_unpack #(.N(N), .ES(ES), .SCW(SCW), .FW(FW)) u_unpack_a (
    .p_i    (a_i),
    .nar_o  (a_nar),
    .zero_o (a_zero),
    .sign_o (a_sign),
    .scale_o(a_scale),
    .sig_o  (a_sig)
  );

  posit_unpack #(.N(N), .ES(ES), .SCW(SCW), .FW(FW)) u_unpack_b (
    .p_i    (b_i),
    .nar_o  (b_nar),
    .zero_o (b_zero),
    .sign_o (b_sign),
    .scale_o(b_scale),
    .sig_o  (b_sig)
  );

  posit_align_add #(.SW(SW), .SCW(SCW), .AW(AW)) u_align_add (
    .a_sign_i (a_sign),
    .a_scale_i(a_scale),
    .a_sig_i  (a_sig),
    .b_sign_i (b_sign),
    .b_scale_i(b_scale),
    .b_sig_i  (b_sig),
    .sign_o   (r_sign),
    .scale_o  (r_scale),
    .sum_o    (r_sum)
  );

  posit_pack #(.N(N), .ES(ES), .SCW(SCW), .AW(AW)) u_pack (
    .sign_i (r_sign),
    .scale_i(r_scale),
    .sum_i  (r_sum),
    .p_o    (packed_sum)
  );

  always_comb begin
    if (a_nar || b_nar)  sel = RES_NAR;
    else if (a_zero)     sel = RES_B;
    else if (b_zero)     sel = RES_A;
    else if (r_sum == '0) sel = RES_ZERO;
    else                 sel = RES_SUM;
  end

  always_comb begin
    unique case (sel)
      RES_NAR:  res = NAR;
      RES_A:    res = a_i;
      RES_B:    res = b_i;
      RES_ZERO: res = '0;
      default:  res = packed_sum;
    endcase
  end

  if (OUT_REG != 0) begin : g_out_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sum_o <= '0;
      else         sum_o <= res;
    end
  end else begin : g_out_comb
    assign sum_o = res;
  end

endmodule

// File: rtl/posit_adder_chk.sv
module posit_adder_chk #(
  parameter int N       = 16,
  parameter int OUT_REG = 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [N-1:0] sum_o
);

  localparam logic [N-1:0] NAR = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] a_q, b_q;
  logic         v_q;

  if (OUT_REG != 0) begin : g_q
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= '0;
        b_q <= '0;
        v_q <= 1'b0;
      end else begin
        a_q <= a_i;
        b_q <= b_i;
        v_q <= 1'b1;
      end
    end
  end else begin : g_c
    assign a_q = a_i;
    assign b_q = b_i;
    assign v_q = rst_ni;
  end

  p_nar_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && (a_q == NAR || b_q == NAR) |-> sum_o == NAR);

  p_zero_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && a_q == '0 && b_q != NAR |-> sum_o == b_q);

  p_cancel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && a_q != NAR && b_q == (~a_q + 1'b1) |-> sum_o == '0);

  p_no_nar_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && a_q != NAR && b_q != NAR |-> sum_o != NAR);

  p_no_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q && a_q != NAR && b_q != NAR && b_q != (~a_q + 1'b1) |-> sum_o != '0);

endmodule

bind posit_adder posit_adder_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/test_posit_adder.sv
module test_posit_adder;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [7:0]  a8, b8;
  logic [7:0]  s8;
  logic [15:0] a16, b16;
  logic [15:0] s16;

  posit_adder #(.N(8), .ES(1), .OUT_REG(1)) i_posit_adder (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a8), .b_i(b8), .sum_o(s8)
  );

  posit_adder #(.N(16), .ES(1), .OUT_REG(1)) i_posit_adder_w16 (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a16), .b_i(b16), .sum_o(s16)
  );

  int n_chk  = 0;
  int n_fail = 0;

  longint val8[256];
  longint mid9[128];

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // value of an n-bit es=1 posit pattern in units of 2^-16
  function automatic longint pval(int n, int unsigned p);
    int unsigned m, u;
    bit s, r0;
    int i, run, k, e, fb, sh;
    longint f, v;
    m = (1 << n) - 1;
    u = p & m;
    if (u == 0) return 0;
    s = u[n-1];
    if (s) u = (~u + 1) & m;
    i = n - 2;
    r0 = u[i];
    run = 0;
    while (i >= 0 && u[i] == r0) begin run++; i--; end
    k = r0 ? run - 1 : -run;
    i--;
    e = 0;
    if (i >= 0) begin e = u[i]; i--; end
    fb = (i >= 0) ? i + 1 : 0;
    f = (i >= 0) ? longint'(u & ((1 << fb) - 1)) : 0;
    sh = 2 * k + e + 16 - fb;
    v = ((longint'(1) << fb) + f) << sh;
    return s ? -v : v;
  endfunction

  function automatic int enc8(longint x);
    if (x >= val8[127]) return 127;
    if (x <= val8[1]) return 1;
    for (int p = 1; p < 127; p++) begin
      if (x >= val8[p] && x < val8[p+1]) begin
        if (x < mid9[p]) return p;
        if (x > mid9[p]) return p + 1;
        return (p % 2 == 0) ? p : p + 1;
      end
    end
    return 0;
  endfunction

  function automatic int ref8(int a, int b);
    longint x;
    if (a == 128 || b == 128) return 128;
    x = val8[a] + val8[b];
    if (x == 0) return 0;
    if (x > 0) return enc8(x);
    return (256 - enc8(-x)) & 255;
  endfunction

  task automatic run8(input logic [7:0] a, input logic [7:0] b, output logic [7:0] r);
    @(negedge clk);
    a8 = a;
    b8 = b;
    @(negedge clk);
    r = s8;
  endtask

  task automatic chk16(string req, logic [15:0] a, logic [15:0] b, logic [15:0] exp);
    @(negedge clk);
    a16 = a;
    b16 = b;
    @(negedge clk);
    chk(req, s16, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r1, r2, r3;
    int pa, pb;
    for (int p = 0; p < 256; p++) val8[p] = pval(8, p);
    for (int p = 0; p < 128; p++) mid9[p] = pval(9, 2 * p + 1);

    rst_n = 1'b0;
    a8 = 8'h40; b8 = 8'h40;
    a16 = 16'h4000; b16 = 16'h4000;
    repeat (3) @(negedge clk);
    chk("R10 reset 8-bit", {8'h0, s8}, 16'h0);
    chk("R10 reset 16-bit", s16, 16'h0);
    rst_n = 1'b1;

    // R10 latency: old value holds until the next edge
    run8(8'h00, 8'h00, r1);
    @(negedge clk);
    a8 = 8'h40; b8 = 8'h40;
    #1;
    chk("R10 before edge", {8'h0, s8}, 16'h0);
    @(negedge clk);
    chk("R10 after edge", {8'h0, s8}, 16'h0050);

    // R1..R7 at default width
    chk16("R1 1+1", 16'h4000, 16'h4000, 16'h5000);
    chk16("R1 1+0.5", 16'h4000, 16'h3000, 16'h4800);
    chk16("R1 1-0.5", 16'h4000, 16'hD000, 16'h3000);
    chk16("R5 3+1", 16'h5800, 16'h4000, 16'h6000);
    chk16("R2 NaR", 16'h8000, 16'h4000, 16'h8000);
    chk16("R3 zero", 16'h0000, 16'h1234, 16'h1234);
    chk16("R4 cancel", 16'h1234, 16'hEDCC, 16'h0000);
    chk16("R6 maxpos", 16'h7FFF, 16'h7FFF, 16'h7FFF);
    chk16("R6 -maxpos", 16'h8001, 16'h8001, 16'h8001);
    chk16("R7 minpos tie", 16'h0001, 16'h0001, 16'h0002);

    // exhaustive 8-bit sweep, pipelined one pair per cycle
    pa = -1; pb = -1;
    for (int i = 0; i <= 65536; i++) begin
      @(negedge clk);
      if (pa >= 0) begin
        int e;
        longint x;
        e = ref8(pa, pb);
        x = val8[pa] + val8[pb];
        if (pa == 128 || pb == 128)      chk("R2", {8'h0, s8}, 16'(e));
        else if (pa == 0 || pb == 0)     chk("R3", {8'h0, s8}, 16'(e));
        else if (x == 0)                 chk("R4", {8'h0, s8}, 16'(e));
        else if (x >= val8[127] || -x >= val8[127]) chk("R6", {8'h0, s8}, 16'(e));
        else if (x < val8[2] && -x < val8[2])       chk("R7", {8'h0, s8}, 16'(e));
        else                             chk("R5", {8'h0, s8}, 16'(e));
      end
      if (i < 65536) begin
        pa = i >> 8;
        pb = i & 255;
        a8 = 8'(pa);
        b8 = 8'(pb);
      end
    end

    // order and sign symmetry
    for (int i = 0; i < 200; i++) begin
      logic [7:0] ta, tb;
      ta = 8'((i * 37 + 5) & 255);
      tb = 8'((i * 91 + 17) & 255);
      run8(ta, tb, r1);
      run8(tb, ta, r2);
      chk("R8", {8'h0, r2}, {8'h0, r1});
      run8(~ta + 8'd1, ~tb + 8'd1, r3);
      chk("R9", {8'h0, r3}, {8'h0, ~r1 + 8'd1});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule